// File: doc/BRIEF.md
# Three-Channel Complementary PWM Dead-Band Generator

This block sits between a PWM timer and the gate drivers of a three-phase bridge. Each channel takes one raw command bit, which selects the high-side (A) or low-side (B) switch. The block drives the matching A and B outputs. While dead-band is enabled for a channel, the active output is first dropped whenever the command changes. A per-channel down-counter then runs out before the opposite output is turned on. This gives the slower turn-off of a power switch time to finish before its partner starts to conduct.

Dead-band lengths come from a 30-bit configuration word holding one 10-bit field per channel. A shared-value mode makes channel 0's field govern all three channels. A separate DC commutation mode drops the normal pairing and routes channel 0's internal A signal to any subset of the six pins. The subset comes from a mask that is written at any time but only takes effect on a period-start pulse. All sizes are parameters; the defaults are three channels and 10-bit counts.

Top module: `deadband_pwm3`

## Requirements
- R1: During and after a synchronous reset, all six outputs are passive (0) and the commutation mask is all zeros. Every dead-time field holds 1023, so the first enabled transition after reset keeps both outputs of the channel passive for 1024 clocks.
- R2: For a channel whose `dt_en` bit is 0, `out_a` equals the command and `out_b` its inverse, with no passive gap between them.
- R3: For an enabled channel, a command change first drops the currently active output. Both outputs then stay passive for D+1 clocks, where D is the channel's dead-time field, and then the requested output becomes active.
- R4: A dead-time field of 0 gives exactly one clock with both outputs of the channel passive.
- R5: If the command reverses while a channel is still in its passive gap, the counter reloads and the newly requested output waits a full D+1 clocks from the reversal. A and B of one channel are never active on the same clock while DC mode is off.
- R6: Field positions in `dt_wdata` are bits 9:0 for channel 0, 19:10 for channel 1 and 29:20 for channel 2. With `ac_mode` = 1, every channel uses the channel 0 field; with `ac_mode` = 0, each channel uses its own field.
- R7: An enabled channel whose outputs are both passive and that is not counting (after reset) activates the commanded output directly, without a gap.
- R8: With `dc_mode` = 1, mask bit 0..5 selects out_a[0], out_b[0], out_a[1], out_b[1], out_a[2], out_b[2] in that order. A selected pin carries channel 0's internal A signal and an unselected pin is passive.
- R9: A mask write changes the live mask only on a cycle with `period_start` = 1. A write made on that same cycle is the value taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_cmd | input | 3 | Raw command per channel, 1 requests A, 0 requests B |
| dt_en | input | 3 | Per-channel dead-band enable |
| dt_wr | input | 1 | Load strobe for the dead-time word |
| dt_wdata | input | 30 | Dead-time word, three 10-bit fields |
| ac_mode | input | 1 | Channel 0 field applies to all channels |
| dc_mode | input | 1 | Route channel 0 A through the commutation mask |
| pat_wr | input | 1 | Write strobe for the commutation mask |
| pat_wdata | input | 6 | Commutation mask write value |
| period_start | input | 1 | Pulse that moves the written mask into the live mask |
| out_a | output | 3 | A outputs, one per channel |
| out_b | output | 3 | B outputs, one per channel |

## Verification
Two events can land in one cycle. A mask write can coincide with the period-start transfer, and a command reversal can arrive while a channel is still counting out its gap. The first is provoked by raising `pat_wr` and `period_start` together, and is judged by reading the six pins in DC mode against the freshly written mask rather than the older one. The second is provoked by flipping a channel's command back the moment its active output is seen to drop. It is judged by counting passive samples: this must come to the full reload length plus the elapsed part of the gap, and the B output must never be seen.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int DBP_NCH = 3;
  localparam int DBP_DTW = 10;

  typedef enum logic {
    PH_STEADY = 1'b0,
    PH_GAP    = 1'b1
  } gap_phase_e;
endpackage

// File: rtl/dbp_cfg.sv
module dbp_cfg
  import dbp_pkg::*;
#(
  parameter int NCH = DBP_NCH,
  parameter int DTW = DBP_DTW,
  localparam int WW = NCH * DTW,
  localparam int PW = 2 * NCH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dt_wr,
  input  logic [WW-1:0]            dt_wdata,
  input  logic                     ac_mode,
  input  logic                     pat_wr,
  input  logic [PW-1:0]            pat_wdata,
  input  logic                     period_start,
  output logic [NCH-1:0][DTW-1:0]  dt_ch,
  output logic [PW-1:0]            pat_live
);
  logic [WW-1:0] dt_q;
  logic [PW-1:0] pat_shadow;

  always_ff @(posedge clk) begin
    if (rst) dt_q <= {WW{1'b1}};
    else if (dt_wr) dt_q <= dt_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_shadow <= '0;
      pat_live   <= '0;
    end else begin
      if (pat_wr) pat_shadow <= pat_wdata;
      if (period_start) pat_live <= pat_wr ? pat_wdata : pat_shadow;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    if (i == 0) begin : g_base
      assign dt_ch[i] = dt_q[DTW-1:0];
    end else begin : g_shared
      assign dt_ch[i] = ac_mode ? dt_q[DTW-1:0] : dt_q[i*DTW +: DTW];
    end
  end

  // R9: the live mask only moves on a period-start cycle
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(pat_live));
  // R9: a write on the transfer cycle is the value taken
  a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (period_start && pat_wr) |=> pat_live == $past(pat_wdata));
endmodule

// File: rtl/dbp_chan.sv
module dbp_chan
  import dbp_pkg::*;
#(
  parameter int DTW = DBP_DTW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           cmd,
  input  logic [DTW-1:0] dt,
  output logic           a_q,
  output logic           b_q
);
  localparam logic [DTW-1:0] CNT_ONE = DTW'(1);

  gap_phase_e     phase;
  logic [DTW-1:0] cnt;
  logic           tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      phase <= PH_STEADY;
      cnt   <= '0;
      tgt   <= 1'b0;
    end else if (!en) begin
      a_q   <= cmd;
      b_q   <= !cmd;
      phase <= PH_STEADY;
      cnt   <= '0;
      tgt   <= cmd;
    end else if (phase == PH_GAP) begin
      if (cmd != tgt) begin
        tgt <= cmd;
        cnt <= dt;
      end else if (cnt == '0) begin
        phase <= PH_STEADY;
        a_q   <= tgt;
        b_q   <= !tgt;
      end else begin
        cnt <= cnt - CNT_ONE;
      end
    end else begin
      if ((cmd && b_q) || (!cmd && a_q)) begin
        a_q   <= 1'b0;
        b_q   <= 1'b0;
        phase <= PH_GAP;
        cnt   <= dt;
        tgt   <= cmd;
      end else if (!a_q && !b_q) begin
        a_q <= cmd;
        b_q <= !cmd;
        tgt <= cmd;
      end
    end
  end

  // R5: the pair is never active together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    a_q |-> !b_q);
  // R3: both outputs stay passive while the gap counter runs
  a_r3_gap_passive: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP) |-> (!a_q && !b_q));
  // R2: a bypassed channel follows its command one clock later
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    !en |=> (a_q == $past(cmd)) && (b_q == !$past(cmd)));
endmodule

// File: rtl/dbp_route.sv
module dbp_route
  import dbp_pkg::*;
#(
  parameter int NCH = DBP_NCH,
  localparam int PW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dc_mode,
  input  logic [PW-1:0]  pat_live,
  input  logic [NCH-1:0] core_a,
  input  logic [NCH-1:0] core_b,
  output logic [NCH-1:0] out_a,
  output logic [NCH-1:0] out_b
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        out_a[i] <= 1'b0;
        out_b[i] <= 1'b0;
      end else if (dc_mode) begin
        out_a[i] <= pat_live[2*i]   & core_a[0];
        out_b[i] <= pat_live[2*i+1] & core_a[0];
      end else begin
        out_a[i] <= core_a[i];
        out_b[i] <= core_b[i];
      end
    end
  end

  // R5: no overlap on the pins outside DC mode
  a_r5_pin_overlap: assert property (@(posedge clk) disable iff (rst)
    !dc_mode |=> (out_a & out_b) == '0);
  // R8: pins left out of the mask stay passive in DC mode
  a_r8_masked_off: assert property (@(posedge clk) disable iff (rst)
    (dc_mode && pat_live[0] == 1'b0) |=> !out_a[0]);
endmodule

// File: rtl/deadband_pwm3.sv
module deadband_pwm3
  import dbp_pkg::*;
#(
  parameter int NCH = DBP_NCH,
  parameter int DTW = DBP_DTW,
  localparam int WW = NCH * DTW,
  localparam int PW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_cmd,
  input  logic [NCH-1:0] dt_en,
  input  logic           dt_wr,
  input  logic [WW-1:0]  dt_wdata,
  input  logic           ac_mode,
  input  logic           dc_mode,
  input  logic           pat_wr,
  input  logic [PW-1:0]  pat_wdata,
  input  logic           period_start,
  output logic [NCH-1:0] out_a,
  output logic [NCH-1:0] out_b
);
  logic [NCH-1:0][DTW-1:0] dt_ch;
  logic [PW-1:0]           pat_live;
  logic [NCH-1:0]          core_a;
  logic [NCH-1:0]          core_b;

  dbp_cfg #(.NCH(NCH), .DTW(DTW)) u_cfg (
    .clk(clk), .rst(rst), .dt_wr(dt_wr), .dt_wdata(dt_wdata),
    .ac_mode(ac_mode), .pat_wr(pat_wr), .pat_wdata(pat_wdata),
    .period_start(period_start), .dt_ch(dt_ch), .pat_live(pat_live)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dbp_chan #(.DTW(DTW)) u_chan (
      .clk(clk), .rst(rst), .en(dt_en[i]), .cmd(chan_cmd[i]),
      .dt(dt_ch[i]), .a_q(core_a[i]), .b_q(core_b[i])
    );
  end

  dbp_route #(.NCH(NCH)) u_route (
    .clk(clk), .rst(rst), .dc_mode(dc_mode), .pat_live(pat_live),
    .core_a(core_a), .core_b(core_b), .out_a(out_a), .out_b(out_b)
  );

  // R1: reset leaves every output passive
  a_r1_reset_passive: assert property (@(posedge clk)
    rst |=> (out_a == '0) && (out_b == '0));
endmodule

// File: tb/sim_deadband_pwm3.sv
module sim_deadband_pwm3;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] chan_cmd = '0;
  logic [2:0] dt_en = '0;
  logic       dt_wr = 1'b0;
  logic [29:0] dt_wdata = '0;
  logic       ac_mode = 1'b0;
  logic       dc_mode = 1'b0;
  logic       pat_wr = 1'b0;
  logic [5:0] pat_wdata = '0;
  logic       period_start = 1'b0;
  logic [2:0] out_a;
  logic [2:0] out_b;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  deadband_pwm3 u0 (
    .clk(clk), .rst(rst), .chan_cmd(chan_cmd), .dt_en(dt_en),
    .dt_wr(dt_wr), .dt_wdata(dt_wdata), .ac_mode(ac_mode),
    .dc_mode(dc_mode), .pat_wr(pat_wr), .pat_wdata(pat_wdata),
    .period_start(period_start), .out_a(out_a), .out_b(out_b)
  );

  function automatic logic [5:0] pins();
    return {out_b[2], out_a[2], out_b[1], out_a[1], out_b[0], out_a[0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_dt(input int f0, input int f1, input int f2);
    @(negedge clk);
    dt_wr = 1'b1;
    dt_wdata = {10'(f2), 10'(f1), 10'(f0)};
    @(negedge clk);
    dt_wr = 1'b0;
  endtask

  // Flip one channel's command and count samples with both outputs passive.
  task automatic gap(input int ch, input logic to_a, output int n);
    int w;
    @(negedge clk);
    chan_cmd[ch] = to_a;
    w = 0;
    while ((to_a ? out_b[ch] : out_a[ch]) && w < 20) begin
      @(negedge clk);
      w++;
    end
    n = 0;
    while (!(to_a ? out_a[ch] : out_b[ch]) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1;
    dt_en = 3'b001;
    chan_cmd = 3'b001;
    wait_cyc(3);
    check(pins() == 6'd0, "R1 outputs passive in reset", pins(), 0);
    rst = 1'b0;
    wait_cyc(3);
    check(out_a[0] && !out_b[0], "R7 direct activation after reset", {out_b[0], out_a[0]}, 1);
    check(!out_a[1] && out_b[1], "R7 direct B activation after reset", {out_b[1], out_a[1]}, 2);
    gap(0, 1'b0, n);
    check(n == 1024, "R1 default dead time", n, 1024);
  endtask

  task automatic t_bypass();
    int n;
    dt_en = 3'b000;
    chan_cmd = 3'b000;
    wait_cyc(4);
    gap(1, 1'b1, n);
    check(n == 0, "R2 bypass no gap to A", n, 0);
    check(out_a[1] && !out_b[1], "R2 bypass levels", {out_b[1], out_a[1]}, 1);
    gap(1, 1'b0, n);
    check(n == 0, "R2 bypass no gap to B", n, 0);
  endtask

  task automatic t_gaps();
    int n;
    write_dt(7, 3, 0);
    ac_mode = 1'b0;
    chan_cmd = 3'b111;
    dt_en = 3'b111;
    wait_cyc(6);
    gap(1, 1'b0, n);
    check(n == 4, "R3 ch1 gap to B", n, 4);
    gap(1, 1'b1, n);
    check(n == 4, "R3 ch1 gap to A", n, 4);
    gap(0, 1'b0, n);
    check(n == 8, "R6 ch0 own field", n, 8);
    gap(2, 1'b0, n);
    check(n == 1, "R4 zero dead time", n, 1);
    gap(2, 1'b1, n);
    check(n == 1, "R4 zero dead time back", n, 1);
  endtask

  task automatic t_reverse();
    int n;
    bit saw_b;
    write_dt(7, 20, 0);
    chan_cmd[1] = 1'b1;
    wait_cyc(30);
    @(negedge clk);
    chan_cmd[1] = 1'b0;
    while (out_a[1]) @(negedge clk);
    chan_cmd[1] = 1'b1;
    n = 0;
    saw_b = 1'b0;
    while (!out_a[1] && n < 5000) begin
      if (out_b[1]) saw_b = 1'b1;
      n++;
      @(negedge clk);
    end
    check(n == 23, "R5 reversal reloads gap", n, 23);
    check(!saw_b, "R5 abandoned B never driven", saw_b, 0);
  endtask

  task automatic t_acmode();
    int n;
    write_dt(5, 12, 30);
    ac_mode = 1'b1;
    chan_cmd = 3'b111;
    wait_cyc(40);
    gap(2, 1'b0, n);
    check(n == 6, "R6 shared field ch2", n, 6);
    gap(1, 1'b0, n);
    check(n == 6, "R6 shared field ch1", n, 6);
    ac_mode = 1'b0;
    gap(2, 1'b1, n);
    check(n == 31, "R6 own field ch2", n, 31);
  endtask

  task automatic t_dc();
    dt_en = 3'b000;
    dc_mode = 1'b1;
    chan_cmd[0] = 1'b1;
    @(negedge clk);
    pat_wr = 1'b1;
    pat_wdata = 6'b100101;
    @(negedge clk);
    pat_wr = 1'b0;
    wait_cyc(4);
    check(pins() == 6'd0, "R9 write waits for period start", pins(), 0);
    period_start = 1'b1;
    @(negedge clk);
    period_start = 1'b0;
    wait_cyc(4);
    check(pins() == 6'b100101, "R8 mask routes A0", pins(), 6'b100101);
    chan_cmd[0] = 1'b0;
    wait_cyc(4);
    check(pins() == 6'd0, "R8 pins track A0 low", pins(), 0);
    chan_cmd[0] = 1'b1;
    @(negedge clk);
    pat_wr = 1'b1;
    pat_wdata = 6'b011010;
    period_start = 1'b1;
    @(negedge clk);
    pat_wr = 1'b0;
    period_start = 1'b0;
    wait_cyc(4);
    check(pins() == 6'b011010, "R9 same-cycle write taken", pins(), 6'b011010);
    @(negedge clk);
    pat_wr = 1'b1;
    pat_wdata = 6'b111111;
    @(negedge clk);
    pat_wr = 1'b0;
    wait_cyc(4);
    check(pins() == 6'b011010, "R9 later write held back", pins(), 6'b011010);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_gaps();
    t_reverse();
    t_acmode();
    t_dc();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #750us;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule